// File: doc/BRIEF.md
# Programmable Clock Output Bank

This block drives three clock outputs. Each output has its own configuration word. The word picks the source clock (slow, main or PLL) and a power-of-two divide ratio from 1 to 64. Software turns outputs on by writing ones to a set address and turns them off by writing ones to a clear address. A status address returns two things: which outputs are on, and which of them have settled.

The three source clocks arrive as plain signals. They are sampled in the register clock domain, so each source must be slower than half the register clock. Each divider counts rising edges of its selected source. The divided output is one bit of that edge counter. When an output is enabled, or reconfigured while it is running, its ready flag drops. The flag comes back after the new waveform has shown two complete rising edges. Software waits for that flag before it relies on the output.

Top module: `pckBank`

## Requirements
- R1: After reset all three outputs are off. Every output is low. The status word reads 0. Every configuration word reads 0, which means slow source and divide by 1.
- R2: Writing address 0 (set) with a 1 in bit i turns output i on. A 0 bit in the same write leaves the other outputs unchanged.
- R3: Writing address 1 (clear) with a 1 in bit i turns output i off. A 0 bit in the same write leaves the other outputs unchanged.
- R4: Reading address 2 returns the on/off image in bits [2:0] and the ready flags in bits [6:4]. The other bits read 0.
- R5: Address 3+i holds the configuration word of output i, and a read returns the stored value.
  - Bits [1:0] select the source: 0 is slow, 1 is main, 2 is PLL, and 3 is also slow.
  - Bits [4:2] hold an exponent p. Any value above 6 acts as 6.
- R6: An enabled output runs at the frequency of its selected source divided by 2^p.
- R7: A disabled output is held low and its ready flag is 0.
- R8: When an output is switched on, its ready flag is 0. The flag becomes 1 after the new output has shown two rising edges, and not before.
- R9: Writing the configuration word of an enabled output clears its ready flag on the next cycle. The flag returns after two rising edges of the reconfigured output.
- R10: Setting an output that is already on does not restart it. Its ready flag and waveform are not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slowSrc | input | 1 | Slow source clock, sampled |
| mainSrc | input | 1 | Main source clock, sampled |
| pllSrc | input | 1 | PLL source clock, sampled |
| wrEn | input | 1 | Write strobe for one cycle |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the current address, combinational |
| clkOut | output | 3 | Divided clock outputs |

## Verification
The assertions check the following on every cycle:
- set and clear writes (R2, R3);
- the effect of zero bits in a set write;
- the forced-low output while an output is off (R7);
- ready never being high on an output that is off;
- the drop of ready after a reconfiguration (R9);
- the survival of ready across a redundant set (R10).

Some properties are visible only in the bench's scenarios:
- the divide ratios, measured for each source and several exponents (R6);
- the clamp of exponent 7;
- the alias of source code 3 to the slow source;
- the earliest and latest cycle at which ready can rise (R8);
- the reset values read back through the register interface (R1).

// File: rtl/pckPkg.sv
package pckPkg;
  localparam int NUM_CH    = 3;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 8;
  localparam int SRC_W     = 2;
  localparam int PRES_W    = 3;
  localparam int CFG_W     = SRC_W + PRES_W;
  localparam int MAX_EXP   = 6;
  localparam int CNT_W     = MAX_EXP;
  localparam int READY_EDGES = 2;
  localparam int RDY_W     = 2;
  localparam int RDY_LSB   = 4;

  localparam logic [ADDR_W-1:0] ADDR_SET  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CLR  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CFG0 = 3'd3;

  typedef enum logic [SRC_W-1:0] {
    SRC_SLOW = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_PLL  = 2'd2,
    SRC_ALT  = 2'd3
  } srcSel_e;

  typedef struct packed {
    logic [PRES_W-1:0] pres;
    srcSel_e           src;
  } chanCfg_t;

  typedef struct packed {
    logic [NUM_CH-1:0] chanOn;
    logic [NUM_CH-1:0] restart;
  } ctrlStrobe_t;
endpackage

// File: rtl/pckCtrl.sv
module pckCtrl
  import pckPkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_CH-1:0]   readyVec,
  output ctrlStrobe_t         strobe,
  output chanCfg_t            cfgArr [NUM_CH],
  output logic [DATA_W-1:0]   rdData
);
  logic [NUM_CH-1:0] enReg;
  logic [NUM_CH-1:0] setHit, clrHit, cfgHit;
  logic              unusedWrBits;

  assign unusedWrBits = ^wrData[DATA_W-1:CFG_W];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(ADDR_CFG0 + i);

    assign setHit[i] = wrEn && (addr == ADDR_SET) && wrData[i];
    assign clrHit[i] = wrEn && (addr == ADDR_CLR) && wrData[i];
    assign cfgHit[i] = wrEn && (addr == CFG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        enReg[i] <= 1'b0;
      end else if (clrHit[i]) begin
        enReg[i] <= 1'b0;
      end else if (setHit[i]) begin
        enReg[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfgArr[i] <= '{pres: '0, src: SRC_SLOW};
      end else if (cfgHit[i]) begin
        cfgArr[i] <= chanCfg_t'(wrData[CFG_W-1:0]);
      end
    end

    // Restart on a fresh enable or on a reconfiguration of a running output.
    assign strobe.restart[i] = (setHit[i] & ~enReg[i]) | (cfgHit[i] & enReg[i]);
  end

  assign strobe.chanOn = enReg;

  always_comb begin
    rdData = '0;
    if (addr == ADDR_STAT) begin
      rdData[NUM_CH-1:0]        = enReg;
      rdData[RDY_LSB +: NUM_CH] = readyVec;
    end
    for (int k = 0; k < NUM_CH; k++) begin
      if (addr == ADDR_W'(ADDR_CFG0 + k)) begin
        rdData[CFG_W-1:0] = cfgArr[k];
      end
    end
  end
endmodule

// File: rtl/pckDatapath.sv
module pckDatapath
  import pckPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slowSrc,
  input  logic              mainSrc,
  input  logic              pllSrc,
  input  ctrlStrobe_t       strobe,
  input  chanCfg_t          cfgArr [NUM_CH],
  output logic [NUM_CH-1:0] clkOut,
  output logic [NUM_CH-1:0] readyVec
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic              srcSel;
    logic              srcQ, srcQ2, srcRise;
    logic [CNT_W-1:0]  divCnt;
    logic [PRES_W-1:0] presEff, bitIdx;
    logic              outRaw, outPrev, outRise;
    logic [RDY_W-1:0]  rdyCnt;
    logic              hold;

    always_comb begin
      unique case (cfgArr[i].src)
        SRC_MAIN: srcSel = mainSrc;
        SRC_PLL:  srcSel = pllSrc;
        default:  srcSel = slowSrc;
      endcase
    end

    assign presEff = (cfgArr[i].pres > PRES_W'(MAX_EXP)) ? PRES_W'(MAX_EXP) : cfgArr[i].pres;
    assign bitIdx  = presEff - PRES_W'(1);
    assign srcRise = srcQ & ~srcQ2;
    assign hold    = ~strobe.chanOn[i] | strobe.restart[i];

    always_comb begin
      if (presEff == '0) outRaw = srcQ;
      else               outRaw = divCnt[bitIdx];
    end

    assign clkOut[i] = strobe.chanOn[i] & outRaw;
    assign outRise   = clkOut[i] & ~outPrev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        srcQ    <= 1'b0;
        srcQ2   <= 1'b0;
        divCnt  <= '0;
        outPrev <= 1'b1;
        rdyCnt  <= '0;
      end else begin
        srcQ  <= srcSel;
        srcQ2 <= srcQ;
        if (hold) begin
          divCnt  <= '0;
          outPrev <= 1'b1;
          rdyCnt  <= '0;
        end else begin
          if (srcRise) divCnt <= divCnt + CNT_W'(1);
          outPrev <= clkOut[i];
          if (outRise && rdyCnt != RDY_W'(READY_EDGES)) rdyCnt <= rdyCnt + RDY_W'(1);
        end
      end
    end

    assign readyVec[i] = strobe.chanOn[i] && (rdyCnt == RDY_W'(READY_EDGES));
  end
endmodule

// File: rtl/pckBank.sv
module pckBank
  import pckPkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slowSrc,
  input  logic              mainSrc,
  input  logic              pllSrc,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] clkOut
);
  ctrlStrobe_t       ctrlStrb;
  chanCfg_t          cfgArr [NUM_CH];
  logic [NUM_CH-1:0] readyVec;
  logic [NUM_CH-1:0] chanOnVec;

  assign chanOnVec = ctrlStrb.chanOn;

  pckCtrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .readyVec(readyVec), .strobe(ctrlStrb), .cfgArr(cfgArr), .rdData(rdData)
  );

  pckDatapath u_dp (
    .clk(clk), .rst_n(rst_n), .slowSrc(slowSrc), .mainSrc(mainSrc), .pllSrc(pllSrc),
    .strobe(ctrlStrb), .cfgArr(cfgArr), .clkOut(clkOut), .readyVec(readyVec)
  );
endmodule

// File: rtl/pckBankChecker.sv
module pckBankChecker
  import pckPkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [NUM_CH-1:0] clkOut,
  input logic [NUM_CH-1:0] chanOn,
  input logic [NUM_CH-1:0] readyVec
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(ADDR_CFG0 + i);

    assert_set_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wrEn && addr == ADDR_SET && wrData[i]) |=> chanOn[i]);

    assert_set_zero_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wrEn && addr == ADDR_SET && !wrData[i]) |=> (chanOn[i] == $past(chanOn[i])));

    assert_clr_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wrEn && addr == ADDR_CLR && wrData[i]) |=> !chanOn[i]);

    assert_clr_zero_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wrEn && addr == ADDR_CLR && !wrData[i]) |=> (chanOn[i] == $past(chanOn[i])));

    assert_off_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !chanOn[i] |-> (!clkOut[i] && !readyVec[i]));

    assert_reconfig_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wrEn && addr == CFG_ADDR && chanOn[i]) |=> !readyVec[i]);

    assert_resend_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wrEn && addr == ADDR_SET && wrData[i] && readyVec[i]) |=> readyVec[i]);
  end
endmodule

bind pckBank pckBankChecker u_pckBankChecker (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .clkOut(clkOut), .chanOn(chanOnVec), .readyVec(readyVec)
);

// File: tb/pckBank_bench.sv
module pckBank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SLOW_PER = 32;
  localparam int MAIN_PER = 8;
  localparam int PLL_PER  = 4;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slowSrc = 1'b0, mainSrc = 1'b0, pllSrc = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] addr = 3'd2;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic [2:0] clkOut;
  int checks = 0, errors = 0;

  pckBank u_pckBank (
    .clk(clk), .rst_n(rst_n), .slowSrc(slowSrc), .mainSrc(mainSrc), .pllSrc(pllSrc),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData), .clkOut(clkOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  initial forever #(CLK_PERIOD*SLOW_PER/2) slowSrc = ~slowSrc;
  initial forever #(CLK_PERIOD*MAIN_PER/2) mainSrc = ~mainSrc;
  initial forever #(CLK_PERIOD*PLL_PER/2)  pllSrc  = ~pllSrc;

  task automatic checkEq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkNear(string req, int act, int exp);
    checks++;
    if (act < exp - 1 || act > exp + 1) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addr = 3'd2; wrData = 8'd0;
  endtask

  task automatic regRead(logic [2:0] a, output int v);
    addr = a;
    #1 v = int'(rdData);
  endtask

  task automatic countRises(int ch, int cycles, output int n);
    logic prev;
    n = 0;
    @(negedge clk);
    prev = clkOut[ch];
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (clkOut[ch] && !prev) n++;
      prev = clkOut[ch];
    end
  endtask

  task automatic idle(int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  task automatic t_reset();
    int v, n;
    regRead(3'd2, v); checkEq("R1 status after reset", v, 0);
    for (int k = 0; k < 3; k++) begin
      regRead(3'(3 + k), v); checkEq("R1 config after reset", v, 0);
    end
    for (int k = 0; k < 3; k++) begin
      countRises(k, 100, n); checkEq("R1 R7 output idle after reset", n, 0);
    end
  endtask

  task automatic t_setClear();
    int v;
    regWrite(3'd0, 8'b001); regRead(3'd2, v); checkEq("R2 set bit0", v & 7, 3'b001);
    regWrite(3'd0, 8'b100); regRead(3'd2, v); checkEq("R2 zero bits keep others", v & 7, 3'b101);
    regWrite(3'd1, 8'b010); regRead(3'd2, v); checkEq("R3 clear of off output keeps others", v & 7, 3'b101);
    regWrite(3'd1, 8'b001); regRead(3'd2, v); checkEq("R3 clear bit0", v & 7, 3'b100);
    regWrite(3'd1, 8'b100); regRead(3'd2, v); checkEq("R3 R4 all off", v, 0);
  endtask

  task automatic runDiv(string req, int ch, int cfg, int srcPer, int expo, int window);
    int v, n, per;
    per = srcPer * (1 << expo);
    regWrite(3'(3 + ch), 8'(cfg));
    regRead(3'(3 + ch), v); checkEq("R5 config readback", v, cfg);
    regWrite(3'd0, 8'(1 << ch));
    idle(3 * per + 10);
    countRises(ch, window, n);
    checkNear(req, n, window / per);
    regWrite(3'd1, 8'(1 << ch));
  endtask

  task automatic t_divide();
    runDiv("R6 slow div1",            0, 8'h00, SLOW_PER, 0, 1024);
    runDiv("R6 main div8",            1, 8'h0D, MAIN_PER, 3, 2048);
    runDiv("R6 pll div2",             2, 8'h06, PLL_PER,  1, 512);
    runDiv("R6 slow div64",           0, 8'h18, SLOW_PER, 6, 8192);
    runDiv("R5 R6 code3 is slow",     1, 8'h03, SLOW_PER, 0, 1024);
    runDiv("R5 R6 exponent7 clamps",  2, 8'h1D, MAIN_PER, 6, 4096);
  endtask

  task automatic t_ready();
    int v;
    regWrite(3'd4, 8'h08);
    regWrite(3'd0, 8'b010);
    regRead(3'd2, v); checkEq("R8 ready low at enable", (v >> 5) & 1, 0);
    idle(100);
    regRead(3'd2, v); checkEq("R8 ready not early", (v >> 5) & 1, 0);
    idle(300);
    regRead(3'd2, v); checkEq("R8 R4 ready after two edges", v, 8'h22);
  endtask

  task automatic t_reconfig();
    int v, n;
    regWrite(3'd4, 8'h05);
    regRead(3'd2, v); checkEq("R9 ready dropped", (v >> 5) & 1, 0);
    idle(3 * 16 + 10);
    regRead(3'd2, v); checkEq("R9 ready restored", (v >> 5) & 1, 1);
    countRises(1, 2048, n); checkNear("R9 R6 new ratio", n, 128);
  endtask

  task automatic t_resend();
    int v, n;
    regWrite(3'd0, 8'b010);
    regRead(3'd2, v); checkEq("R10 ready kept on resend", (v >> 5) & 1, 1);
    countRises(1, 1024, n); checkNear("R10 waveform kept", n, 64);
  endtask

  task automatic t_offLow();
    int v, n;
    regWrite(3'd1, 8'b010);
    regRead(3'd2, v); checkEq("R7 ready cleared when off", v, 0);
    countRises(1, 300, n); checkEq("R7 output held low", n, 0);
    checkEq("R7 output level", int'(clkOut[1]), 0);
  endtask

  initial begin
    idle(4);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    t_reset();
    t_setClear();
    t_divide();
    t_ready();
    t_reconfig();
    t_resend();
    t_offLow();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule